// File: doc/BRIEF.md
# Buffered Full-Duplex Serial Transceiver

This block moves words between a processor and a pair of serial lines. Software writes a word into a one-entry transmit buffer. Software reads received words from a one-entry receive holding register. The hardware handles the bit-level work. It shifts each word out and in least significant bit first, one bit time at a time. The bit time is set by a divider with one-system-clock granularity. Each direction has its own frame length, anywhere from 1 to 32 bits.

Because each side has one word of buffering behind its shifter, frames can follow each other with no idle bit between them. Software only has to refill or drain the buffer once per frame.

In asynchronous mode each frame is wrapped in a low start bit and a high stop bit. In synchronous mode the framing bits are dropped, and a bit clock is driven out while the transmitter shifts. The receiver then samples on that clock, which gives an SPI-like full-duplex master. All handshake flags, error flags and bit counters can be read together as one 32-bit status word.

Top module: `sertrx_core`

## Requirements
- R1: One bit lasts `cfg_div + 1` system clocks, with `cfg_div` at least 3. `ser_out` is 1 whenever the transmitter is idle.
- R2: An asynchronous transmit frame has three parts, in this order:
  - a 0 start bit;
  - `cfg_tx_len + 1` data bits, least significant first, taken from the low bits of the written word;
  - a 1 stop bit.
- R3: In synchronous mode no start or stop bit is sent. `sclk_out` is 0 for the first `(cfg_div+1)/2` clocks (rounded down) of each transmitted bit and 1 for the rest. `sclk_out` is always 0 when the transmitter is idle or when asynchronous mode is selected.
- R4: A `tx_wr` pulse is accepted only while the ready flag (status bit 1) is 1, and clears that flag. A write while the flag is 0 is ignored. The flag returns to 1 on the clock after the buffered word moves into the shifter.
- R5: When the last bit of a frame ends and a word is buffered, that word enters the shifter on the same clock. Its first bit follows with no idle time.
- R6: The asynchronous receiver works on the line after a two-flop synchronizer:
  - a falling edge starts reception, and the start bit is re-checked at mid-bit;
  - `cfg_rx_len + 1` data bits are then sampled at bit centres, least significant first;
  - the word is delivered right-aligned and zero-extended;
  - a stop bit sampled as 0 sets the framing-error flag (status bit 3) and the word is dropped.
- R7: In synchronous mode the receiver takes `ser_in` during the first clock of each high phase of `sclk_out`. It delivers a word every `cfg_rx_len + 1` bits, independent of the transmit length.
- R8: A delivered word sets the valid flag (status bit 0). An `rx_rd` pulse clears the valid flag, the overrun flag and the framing-error flag.
- R9: A word that completes while the valid flag is 1 and `rx_rd` is 0 is dropped. It sets the overrun flag (status bit 2), and `rx_rdata` keeps the older word.
- R10: The status word is laid out as follows; after reset it reads 0x00000002.

  | Bits | Field |
  |---|---|
  | 0 | rx valid |
  | 1 | tx ready |
  | 2 | overrun |
  | 3 | framing error |
  | 4 | tx busy |
  | 5 | rx busy |
  | 11:6 | transmit bits remaining in the current frame |
  | 17:12 | receive bits taken so far |
  | 31:18 | zero |

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_async | input | 1 | 1 selects start/stop framing, 0 selects clocked synchronous mode |
| cfg_div | input | DIV_W | Bit time minus one, in system clocks |
| cfg_tx_len | input | 5 | Transmit frame length minus one |
| cfg_rx_len | input | 5 | Receive frame length minus one |
| tx_wr | input | 1 | Write strobe for the transmit buffer |
| tx_wdata | input | 32 | Word to transmit |
| rx_rd | input | 1 | Read strobe acknowledging the receive holding register |
| rx_rdata | output | 32 | Receive holding register |
| status_word | output | 32 | Packed flags and counters |
| ser_in | input | 1 | Serial data in |
| ser_out | output | 1 | Serial data out |
| sclk_out | output | 1 | Bit clock output in synchronous mode |

## Verification
A corrupted transmit counter or shifter shows on `ser_out`, `sclk_out` and the ready flag within one bit time. For that reason a behavioural model of the transmit line is compared against those pins, and against the remaining-bit count, on every clock. Receiver faults are caught with a loopback path, where each delivered word must equal the word written earlier. These faults include wrong sampling point, wrong alignment, lost or duplicated words, and flags that fail to set or clear. They surface no later than the end of the affected frame.

// File: rtl/sertrx_pkg.sv
package sertrx_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned LEN_W  = $clog2(WORD_W);
  localparam int unsigned FRM_W  = WORD_W + 2;
  localparam int unsigned CNT_W  = $clog2(FRM_W + 1);

  typedef struct packed {
    logic [31-2*CNT_W-6:0] zero;
    logic [CNT_W-1:0]      rx_bits;
    logic [CNT_W-1:0]      tx_bits;
    logic                  rx_busy;
    logic                  tx_busy;
    logic                  frame_err;
    logic                  overrun;
    logic                  tx_ready;
    logic                  rx_valid;
  } status_t;

  // number of line bits in one transmitted frame
  function automatic logic [CNT_W-1:0] frame_bits(input logic async_en,
                                                  input logic [LEN_W-1:0] len_m1);
    frame_bits = CNT_W'(len_m1) + CNT_W'(1) + (async_en ? CNT_W'(2) : CNT_W'(0));
  endfunction

  // low len_m1+1 bits set
  function automatic logic [WORD_W-1:0] len_mask(input logic [LEN_W-1:0] len_m1);
    logic [WORD_W:0] one;
    one = (WORD_W+1)'(1) << (CNT_W'(len_m1) + CNT_W'(1));
    len_mask = WORD_W'(one - (WORD_W+1)'(1));
  endfunction

  // line bits, bit 0 goes out first
  function automatic logic [FRM_W-1:0] build_frame(input logic [WORD_W-1:0] data,
                                                   input logic [LEN_W-1:0] len_m1,
                                                   input logic async_en);
    logic [WORD_W-1:0] m;
    m = data & len_mask(len_m1);
    if (async_en)
      build_frame = {1'b0, m, 1'b0} | (FRM_W'(1) << (CNT_W'(len_m1) + CNT_W'(2)));
    else
      build_frame = FRM_W'(m);
  endfunction

  // bits enter at the top of the shifter; bring them down to bit 0
  function automatic logic [WORD_W-1:0] rx_align(input logic [WORD_W-1:0] sh,
                                                 input logic [LEN_W-1:0] len_m1);
    rx_align = sh >> (LEN_W'(WORD_W-1) - len_m1);
  endfunction
endpackage

// File: rtl/sertrx_tx.sv
module sertrx_tx
  import sertrx_pkg::*;
#(
  parameter int unsigned DIV_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                async_en,
  input  logic [DIV_W-1:0]    div,
  input  logic [LEN_W-1:0]    len_m1,
  input  logic                wr,
  input  logic [WORD_W-1:0]   wdata,
  output logic                ser_out,
  output logic                sclk_out,
  output logic                mid_stb,
  output logic                tx_ready,
  output logic                tx_busy,
  output logic [CNT_W-1:0]    bits_left,
  output logic                load_evt
);
  logic [DIV_W-1:0]  tcnt;
  logic [FRM_W-1:0]  sh;
  logic [CNT_W-1:0]  left;
  logic              full;
  logic [WORD_W-1:0] hold;
  logic [DIV_W:0]    div_p1;
  logic [DIV_W-1:0]  half;
  logic              bit_end;
  logic              last_end;

  assign div_p1   = {1'b0, div} + (DIV_W+1)'(1);
  assign half     = div_p1[DIV_W:1];
  assign tx_busy  = (left != '0);
  assign bit_end  = tx_busy && (tcnt == div);
  assign last_end = bit_end && (left == CNT_W'(1));
  assign load_evt = full && (!tx_busy || last_end);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      hold <= '0;
    end else if (wr && !full) begin
      full <= 1'b1;
      hold <= wdata;
    end else if (load_evt) begin
      full <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '0;
      left <= '0;
      tcnt <= '0;
    end else if (load_evt) begin
      sh   <= build_frame(hold, len_m1, async_en);
      left <= frame_bits(async_en, len_m1);
      tcnt <= '0;
    end else if (bit_end) begin
      sh   <= sh >> 1;
      left <= left - CNT_W'(1);
      tcnt <= '0;
    end else if (tx_busy) begin
      tcnt <= tcnt + DIV_W'(1);
    end
  end

  assign ser_out   = tx_busy ? sh[0] : 1'b1;
  assign sclk_out  = tx_busy && !async_en && (tcnt >= half);
  assign mid_stb   = tx_busy && !async_en && (tcnt == half);
  assign tx_ready  = !full;
  assign bits_left = left;
endmodule

// File: rtl/sertrx_rx.sv
module sertrx_rx
  import sertrx_pkg::*;
#(
  parameter int unsigned DIV_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                async_en,
  input  logic [DIV_W-1:0]    div,
  input  logic [LEN_W-1:0]    len_m1,
  input  logic                ser_in,
  input  logic                sync_stb,
  input  logic                rd,
  output logic [WORD_W-1:0]   rdata,
  output logic                rx_valid,
  output logic                overrun,
  output logic                frame_err,
  output logic                rx_busy,
  output logic [CNT_W-1:0]    bits_got,
  output logic                deliver_evt
);
  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;

  rx_state_e         st;
  logic              s1, s2, s3;
  logic [DIV_W-1:0]  rcnt;
  logic [CNT_W-1:0]  nbits;
  logic [WORD_W-1:0] sh;
  logic [WORD_W-1:0] sh_next;
  logic [WORD_W-1:0] word_in;
  logic              take;
  logic              take_val;
  logic              last_bit;
  logic              stop_due;
  logic              ferr_evt;
  logic              fall;

  assign fall     = s3 && !s2;
  assign stop_due = async_en && (st == RX_STOP) && (rcnt == div);
  assign take     = async_en ? ((st == RX_DATA) && (rcnt == div)) : sync_stb;
  assign take_val = async_en ? s2 : ser_in;
  assign last_bit = (nbits == CNT_W'(len_m1));
  assign sh_next  = {take_val, sh[WORD_W-1:1]};

  assign deliver_evt = async_en ? (stop_due && s2) : (take && last_bit);
  assign ferr_evt    = stop_due && !s2;
  assign word_in     = rx_align(async_en ? sh : sh_next, len_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
      s3 <= 1'b1;
    end else begin
      s1 <= ser_in;
      s2 <= s1;
      s3 <= s2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= RX_IDLE;
      rcnt  <= '0;
      nbits <= '0;
      sh    <= '0;
    end else begin
      if (take) sh <= sh_next;
      if (!async_en) begin
        st   <= RX_IDLE;
        rcnt <= '0;
        if (take) nbits <= last_bit ? '0 : nbits + CNT_W'(1);
      end else begin
        unique case (st)
          RX_IDLE: begin
            nbits <= '0;
            if (fall) begin
              st   <= RX_START;
              rcnt <= '0;
            end
          end
          RX_START: begin
            if (rcnt == (div >> 1)) begin
              rcnt <= '0;
              st   <= s2 ? RX_IDLE : RX_DATA;
            end else begin
              rcnt <= rcnt + DIV_W'(1);
            end
          end
          RX_DATA: begin
            if (take) begin
              rcnt  <= '0;
              nbits <= nbits + CNT_W'(1);
              if (last_bit) st <= RX_STOP;
            end else begin
              rcnt <= rcnt + DIV_W'(1);
            end
          end
          RX_STOP: begin
            if (stop_due) begin
              st    <= RX_IDLE;
              rcnt  <= '0;
              nbits <= '0;
            end else begin
              rcnt <= rcnt + DIV_W'(1);
            end
          end
          default: st <= RX_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata     <= '0;
      rx_valid  <= 1'b0;
      overrun   <= 1'b0;
      frame_err <= 1'b0;
    end else begin
      if (deliver_evt && (!rx_valid || rd)) begin
        rdata    <= word_in;
        rx_valid <= 1'b1;
      end else if (rd) begin
        rx_valid <= 1'b0;
      end
      if (deliver_evt && rx_valid && !rd) overrun <= 1'b1;
      else if (rd)                        overrun <= 1'b0;
      if (ferr_evt)  frame_err <= 1'b1;
      else if (rd)   frame_err <= 1'b0;
    end
  end

  assign rx_busy  = (st != RX_IDLE) || (nbits != '0);
  assign bits_got = nbits;
endmodule

// File: rtl/sertrx_stat.sv
module sertrx_stat
  import sertrx_pkg::*;
(
  input  logic              rx_valid,
  input  logic              tx_ready,
  input  logic              overrun,
  input  logic              frame_err,
  input  logic              tx_busy,
  input  logic              rx_busy,
  input  logic [CNT_W-1:0]  tx_bits,
  input  logic [CNT_W-1:0]  rx_bits,
  output logic [WORD_W-1:0] word
);
  status_t s;
  always_comb begin
    s           = '0;
    s.rx_valid  = rx_valid;
    s.tx_ready  = tx_ready;
    s.overrun   = overrun;
    s.frame_err = frame_err;
    s.tx_busy   = tx_busy;
    s.rx_busy   = rx_busy;
    s.tx_bits   = tx_bits;
    s.rx_bits   = rx_bits;
  end
  assign word = s;
endmodule

// File: rtl/sertrx_core.sv
module sertrx_core
  import sertrx_pkg::*;
#(
  parameter int unsigned DIV_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_async,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic [4:0]        cfg_tx_len,
  input  logic [4:0]        cfg_rx_len,
  input  logic              tx_wr,
  input  logic [31:0]       tx_wdata,
  input  logic              rx_rd,
  output logic [31:0]       rx_rdata,
  output logic [31:0]       status_word,
  input  logic              ser_in,
  output logic              ser_out,
  output logic              sclk_out
);
  logic             tx_ready_w, tx_busy_w, tx_load_evt, mid_stb;
  logic [CNT_W-1:0] tx_left;
  logic             rx_valid_w, ovr_w, ferr_w, rx_busy_w, rx_deliver_evt;
  logic [CNT_W-1:0] rx_got;

  sertrx_tx #(.DIV_W(DIV_W)) tx_i (
    .clk(clk), .rst_n(rst_n), .async_en(cfg_async), .div(cfg_div),
    .len_m1(cfg_tx_len), .wr(tx_wr), .wdata(tx_wdata),
    .ser_out(ser_out), .sclk_out(sclk_out), .mid_stb(mid_stb),
    .tx_ready(tx_ready_w), .tx_busy(tx_busy_w), .bits_left(tx_left),
    .load_evt(tx_load_evt)
  );

  sertrx_rx #(.DIV_W(DIV_W)) rx_i (
    .clk(clk), .rst_n(rst_n), .async_en(cfg_async), .div(cfg_div),
    .len_m1(cfg_rx_len), .ser_in(ser_in), .sync_stb(mid_stb), .rd(rx_rd),
    .rdata(rx_rdata), .rx_valid(rx_valid_w), .overrun(ovr_w),
    .frame_err(ferr_w), .rx_busy(rx_busy_w), .bits_got(rx_got),
    .deliver_evt(rx_deliver_evt)
  );

  sertrx_stat stat_i (
    .rx_valid(rx_valid_w), .tx_ready(tx_ready_w), .overrun(ovr_w),
    .frame_err(ferr_w), .tx_busy(tx_busy_w), .rx_busy(rx_busy_w),
    .tx_bits(tx_left), .rx_bits(rx_got), .word(status_word)
  );
endmodule

// File: rtl/sertrx_chk.sv
module sertrx_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_async,
  input logic        tx_wr,
  input logic        rx_rd,
  input logic [31:0] rx_rdata,
  input logic [31:0] status_word,
  input logic        ser_out,
  input logic        sclk_out,
  input logic        tx_load_evt,
  input logic        rx_deliver_evt
);
  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !status_word[4] |-> ser_out); // R1
  AST_SCLK_QUIET_ASYNC: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_async || !status_word[4]) |-> !sclk_out); // R3
  AST_READY_DROPS_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr && status_word[1]) |=> !status_word[1]); // R4
  AST_READY_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load_evt |=> status_word[1]); // R4
  AST_DELIVER_SETS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    rx_deliver_evt |=> status_word[0]); // R8
  AST_VALID_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (status_word[0] && !rx_rd) |=> status_word[0]); // R8
  AST_OLD_WORD_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (status_word[0] && !rx_rd) |=> $stable(rx_rdata)); // R9
  AST_OVR_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_word[2]) |-> $past(status_word[0])); // R9
endmodule

bind sertrx_core sertrx_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_async(cfg_async), .tx_wr(tx_wr),
  .rx_rd(rx_rd), .rx_rdata(rx_rdata), .status_word(status_word),
  .ser_out(ser_out), .sclk_out(sclk_out), .tx_load_evt(tx_load_evt),
  .rx_deliver_evt(rx_deliver_evt)
);

// File: tb/sertrx_core_tb_top.sv
module sertrx_core_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_async = 1'b1;
  logic [15:0] cfg_div = 16'd3;
  logic [4:0]  cfg_tx_len = 5'd7;
  logic [4:0]  cfg_rx_len = 5'd7;
  logic        tx_wr = 1'b0;
  logic [31:0] tx_wdata = '0;
  logic        rx_rd = 1'b0;
  logic [31:0] rx_rdata;
  logic [31:0] status_word;
  logic        ser_in;
  logic        ser_out;
  logic        sclk_out;
  logic        loop_en = 1'b1;
  logic        drv_in = 1'b1;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  assign ser_in = loop_en ? ser_out : drv_in;

  sertrx_core dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_async(cfg_async), .cfg_div(cfg_div),
    .cfg_tx_len(cfg_tx_len), .cfg_rx_len(cfg_rx_len), .tx_wr(tx_wr),
    .tx_wdata(tx_wdata), .rx_rd(rx_rd), .rx_rdata(rx_rdata),
    .status_word(status_word), .ser_in(ser_in), .ser_out(ser_out),
    .sclk_out(sclk_out)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural model of the transmit line: a queue of line levels
  bit     mq[$];
  int     m_tick = 0;
  bit     m_full = 0;
  bit     m_fb;
  logic [31:0] m_buf = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      mq.delete();
      m_tick = 0;
      m_full = 0;
    end else begin
      m_fb = m_full;
      if (mq.size() != 0) begin
        if (m_tick == int'(cfg_div)) begin
          void'(mq.pop_front());
          m_tick = 0;
        end else m_tick++;
      end
      if (m_fb && mq.size() == 0) begin
        if (cfg_async) mq.push_back(1'b0);
        for (int i = 0; i <= int'(cfg_tx_len); i++) mq.push_back(m_buf[i]);
        if (cfg_async) mq.push_back(1'b1);
        m_tick = 0;
        m_full = 0;
      end
      if (tx_wr && !m_fb) begin
        m_full = 1;
        m_buf  = tx_wdata;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit e_out, e_sclk;
      e_out  = (mq.size() != 0) ? mq[0] : 1'b1;
      e_sclk = !cfg_async && (mq.size() != 0) && (m_tick >= (int'(cfg_div) + 1) / 2);
      check(ser_out == e_out, "R2/R5 ser_out", ser_out, e_out);
      check(sclk_out == e_sclk, "R3 sclk_out", sclk_out, e_sclk);
      check(status_word[1] == !m_full, "R4 tx_ready", status_word[1], !m_full);
      check(int'(status_word[11:6]) == mq.size(), "R10 tx bits left", status_word[11:6], mq.size());
      check(status_word[4] == (mq.size() != 0), "R1 tx busy", status_word[4], mq.size() != 0);
    end
  end

  task automatic set_cfg(input bit a, input int d, input int tl, input int rl);
    cfg_async  = a;
    cfg_div    = 16'(d);
    cfg_tx_len = 5'(tl);
    cfg_rx_len = 5'(rl);
    @(negedge clk);
  endtask

  task automatic send(input logic [31:0] w);
    while (!status_word[1]) @(negedge clk);
    tx_wr = 1'b1;
    tx_wdata = w;
    @(negedge clk);
    tx_wr = 1'b0;
  endtask

  task automatic wait_rx(input logic [31:0] exp, input string req);
    int n = 0;
    while (!status_word[0] && n < 4000) begin
      @(negedge clk);
      n++;
    end
    check(status_word[0] == 1'b1, {req, " valid"}, status_word[0], 1);
    check(rx_rdata == exp, {req, " data"}, rx_rdata, exp);
    rx_rd = 1'b1;
    @(negedge clk);
    rx_rd = 1'b0;
    check(status_word[0] == 1'b0, "R8 valid cleared by read", status_word[0], 0);
  endtask

  task automatic wait_tx_idle();
    while (status_word[4] || !status_word[1]) @(negedge clk);
  endtask

  task automatic drive_bit(input bit b, input int t);
    drv_in = b;
    repeat (t) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset value
    check(status_word == 32'h0000_0002, "R10 reset status", status_word, 32'h2);
    check(ser_out == 1'b1, "R1 idle line", ser_out, 1);

    // R2 R6 async loopback, 8 bits
    set_cfg(1, 3, 7, 7);
    send(32'h0000_00A5);
    wait_rx(32'h0000_00A5, "R6 async byte");

    // R5 back-to-back plus R4 ignored write
    send(32'h0000_0011);
    send(32'h0000_0022);
    check(status_word[1] == 1'b0, "R4 ready low while buffered", status_word[1], 0);
    tx_wr = 1'b1; tx_wdata = 32'h0000_00FF;
    @(negedge clk);
    tx_wr = 1'b0;
    wait_rx(32'h0000_0011, "R5 first of pair");
    wait_rx(32'h0000_0022, "R5 second of pair");
    repeat (200) @(negedge clk);
    check(status_word[0] == 1'b0, "R4 ignored write sent nothing", status_word[0], 0);

    // R1 R6 full width, longer bit time
    set_cfg(1, 5, 31, 31);
    send(32'hDEAD_BEEF);
    wait_rx(32'hDEAD_BEEF, "R6 32-bit word");

    // R2 R6 single-bit and short frames, high bits masked
    set_cfg(1, 4, 0, 0);
    send(32'hFFFF_FFFF);
    wait_rx(32'h0000_0001, "R6 one-bit frame");
    set_cfg(1, 3, 4, 4);
    send(32'hFFFF_FF13);
    wait_rx(32'h0000_0013, "R6 five-bit frame");

    // R9 overrun
    set_cfg(1, 3, 7, 7);
    send(32'h0000_0055);
    send(32'h0000_0066);
    wait_tx_idle();
    repeat (20) @(negedge clk);
    check(status_word[0] == 1'b1, "R9 valid still set", status_word[0], 1);
    check(status_word[2] == 1'b1, "R9 overrun flag", status_word[2], 1);
    check(rx_rdata == 32'h55, "R9 older word kept", rx_rdata, 32'h55);
    rx_rd = 1'b1;
    @(negedge clk);
    rx_rd = 1'b0;
    check(status_word[2:0] == 3'b010, "R8 read clears flags", status_word[2:0], 3'b010);

    // R6 framing error with a low stop bit
    loop_en = 1'b0;
    drv_in = 1'b1;
    repeat (5) @(negedge clk);
    drive_bit(0, 4);
    for (int i = 0; i < 8; i++) drive_bit(i[0], 4);
    drive_bit(0, 4);
    drive_bit(1, 20);
    check(status_word[3] == 1'b1, "R6 framing error set", status_word[3], 1);
    check(status_word[0] == 1'b0, "R6 bad frame dropped", status_word[0], 0);
    rx_rd = 1'b1;
    @(negedge clk);
    rx_rd = 1'b0;
    check(status_word[3] == 1'b0, "R8 read clears framing error", status_word[3], 0);
    loop_en = 1'b1;
    repeat (4) @(negedge clk);

    // R3 R7 synchronous mode, tx 16 bits, rx 8 bits
    set_cfg(0, 3, 15, 7);
    send(32'h0000_3C5A);
    wait_rx(32'h0000_005A, "R7 sync low byte");
    wait_rx(32'h0000_003C, "R7 sync high byte");
    send(32'h0000_1234);
    send(32'h0000_ABCD);
    wait_rx(32'h34, "R7 gapless byte 0");
    wait_rx(32'h12, "R7 gapless byte 1");
    wait_rx(32'hCD, "R7 gapless byte 2");
    wait_rx(32'hAB, "R7 gapless byte 3");
    wait_tx_idle();
    repeat (4) @(negedge clk);
    check(sclk_out == 1'b0, "R3 clock idle low", sclk_out, 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule